// File: doc/BRIEF.md
# Trapezoidal Step-Rate Profile Generator

This block plans a point-to-point move for a single stepper axis. A move arrives as a signed step count plus a requested top speed. From it the block produces a budget for each control tick: how many motor steps the axis may issue during that tick. The pulse timing inside a tick belongs to a downstream stage. Speeds are quantised to the integer levels 1 through 4 steps per tick. The rate climbs one level per tick from rest, cruises at the effective top speed, and then falls back one level per tick. The total issued matches the commanded distance exactly. A move too short to reach the top speed produces a triangular shape.

The command port is valid/ready. The block raises `cmd_ready` only when it has no move in progress. The upstream source must hold `cmd_valid` and its data until it sees `cmd_ready`. Any offer made while a move runs is neither captured nor queued. The tick strobe comes from a fixed-period timer. Each tick that falls during a move yields one `step_stb` pulse on the following cycle, carrying the budget and the latched direction. `done` marks the end of every move, including moves of zero length.

Top module: `stepper_trap_profile`

## Requirements
- R1: `cmd_ready` is 1 exactly when no move is running, and a command transfers on a cycle where `cmd_valid` and `cmd_ready` are both 1. While a move runs, `cmd_valid` and the command fields are ignored: no second move starts after the current one ends.
- R2: The effective top speed is the requested value clamped to the range 1..4, where 0 counts as 1 and any value above 4 counts as 4. No tick budget exceeds it.
- R3: The first tick of a move issues 1 step. Between consecutive issued ticks of a move, the budget rises or falls by at most 1.
- R4: The budgets of a move add up to exactly the magnitude of the commanded count. This includes the most negative count.
- R5: On each tick the budget is the largest candidate v ≥ 1, taken in the order min(prev+1, top), prev, prev−1, for which v·(v+1)/2 ≤ remaining steps. Here prev is the previous budget, 0 at the start of a move. As a result, the last tick of every nonzero move issues 1 step.
- R6: `step_stb` pulses for one cycle, with `step_cnt` holding the budget, on the cycle after a `tick` that sees a running move. A tick while idle, or in the same cycle as the command transfer, produces no pulse. `step_cnt` is 0 whenever `step_stb` is 0.
- R7: `done` pulses for one cycle together with the final `step_stb` of a move, and `busy` is 0 in that cycle.
- R8: A command with count 0 gives `done` = 1 on the cycle after the transfer, with no `step_stb` and `busy` remaining 0.
- R9: `step_dir` is 1 for a negative count and 0 otherwise. It is updated on the command transfer and held for the whole move.
- R10: During reset and right after it, `busy`, `done`, `step_stb` and `step_cnt` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Move command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_steps | input | CNT_W | Signed step count of the move |
| cmd_peak | input | PK_W | Requested top speed in steps per tick |
| tick | input | 1 | Control-period strobe, one cycle wide |
| step_stb | output | 1 | Budget for the last tick is valid |
| step_cnt | output | LVL_W | Steps to issue in this tick |
| step_dir | output | 1 | 1 = negative direction |
| busy | output | 1 | Move in progress |
| done | output | 1 | Move finished (one-cycle pulse) |

## Verification
The assertions check several properties on every cycle. No budget exceeds the remaining distance or the latched top speed. The level moves by at most one per tick. Direction stays stable through a move. An accepted command always produces either busy or done. `done` never coincides with `busy`. The exact budget sequence needs the bench's scenarios to show: its plateau placement, its triangular shapes, and the exact total. So do the clamp of odd peak requests, the ignored offers during a move, a tick in the transfer cycle, and the zero-length and extreme-count moves.

// File: rtl/stp_prof_pkg.sv
package stp_prof_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // steps consumed by ramping a level v down to rest, inclusive of v
  function automatic int unsigned ramp_sum(input int unsigned v);
    return (v * (v + 1)) / 2;
  endfunction

endpackage

// File: rtl/stp_cmd_latch.sv
module stp_cmd_latch #(
  parameter int CNT_W   = 16,
  parameter int PK_W    = 3,
  parameter int MAX_LVL = 4,
  parameter int LVL_W   = $clog2(MAX_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cmd_steps,
  input  logic [PK_W-1:0]  cmd_peak,
  output logic [CNT_W-1:0] mag,
  output logic             dir_q,
  output logic [LVL_W-1:0] peak_q
);

  localparam int PKX_W = (PK_W > LVL_W) ? PK_W : LVL_W;

  logic             neg;
  logic [PKX_W-1:0] pk_ext;
  logic [LVL_W-1:0] peak_eff;

  assign neg = cmd_steps[CNT_W-1];
  assign mag = neg ? (~cmd_steps + {{(CNT_W-1){1'b0}}, 1'b1}) : cmd_steps;

  assign pk_ext = PKX_W'(cmd_peak);

  always_comb begin
    if (pk_ext == '0)
      peak_eff = LVL_W'(1);
    else if (pk_ext > PKX_W'(MAX_LVL))
      peak_eff = LVL_W'(MAX_LVL);
    else
      peak_eff = LVL_W'(pk_ext);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      peak_q <= LVL_W'(1);
    end else if (load) begin
      dir_q  <= neg;
      peak_q <= peak_eff;
    end
  end

  // R2: latched top speed always inside 1..MAX_LVL
  a_r2_peak_range: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (peak_q != '0) && (peak_q <= LVL_W'(MAX_LVL)));

endmodule

// File: rtl/stp_level_sel.sv
module stp_level_sel
  import stp_prof_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MAX_LVL = 4,
  parameter int LVL_W   = $clog2(MAX_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] peak,
  input  logic [CNT_W-1:0] remaining,
  output logic [LVL_W-1:0] nxt_lvl
);

  localparam int NCAND = 3;

  logic [LVL_W-1:0] cand [NCAND];
  logic [NCAND-1:0] ok;

  assign cand[0] = (lvl < peak) ? lvl + LVL_W'(1) : lvl;
  assign cand[1] = lvl;
  assign cand[2] = (lvl > LVL_W'(1)) ? lvl - LVL_W'(1) : LVL_W'(1);

  for (genvar i = 0; i < NCAND; i++) begin : g_fit
    assign ok[i] = (cand[i] != '0) &&
                   (ramp_sum(32'(cand[i])) <= 32'(remaining));
  end

  always_comb begin
    nxt_lvl = '0;
    for (int i = NCAND - 1; i >= 0; i--) begin
      if (ok[i]) nxt_lvl = cand[i];
    end
  end

  // R5: a nonzero distance always yields a usable level
  a_r5_level_found: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining != '0) |-> (nxt_lvl != '0));

endmodule

// File: rtl/stp_budget.sv
module stp_budget #(
  parameter int CNT_W   = 16,
  parameter int MAX_LVL = 4,
  parameter int LVL_W   = $clog2(MAX_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_mag,
  input  logic             tick,
  input  logic [LVL_W-1:0] nxt_lvl,
  output logic [CNT_W-1:0] remaining,
  output logic [LVL_W-1:0] lvl,
  output logic             busy,
  output logic             step_stb,
  output logic [LVL_W-1:0] step_cnt,
  output logic             done
);

  logic adv;
  logic last;

  assign adv  = busy && tick;
  assign last = (remaining == CNT_W'(nxt_lvl));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      lvl       <= '0;
      busy      <= 1'b0;
      step_stb  <= 1'b0;
      step_cnt  <= '0;
      done      <= 1'b0;
    end else begin
      step_stb <= 1'b0;
      step_cnt <= '0;
      done     <= 1'b0;
      if (load) begin
        remaining <= load_mag;
        lvl       <= '0;
        busy      <= (load_mag != '0);
        done      <= (load_mag == '0);
      end else if (adv) begin
        remaining <= remaining - CNT_W'(nxt_lvl);
        lvl       <= nxt_lvl;
        step_stb  <= 1'b1;
        step_cnt  <= nxt_lvl;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R4: never spend more than what is left
  a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (CNT_W'(nxt_lvl) <= remaining));

  // R3: level moves by at most one per tick
  a_r3_ramp_rate: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> ((nxt_lvl <= lvl + LVL_W'(1)) && (nxt_lvl + LVL_W'(1) >= lvl)));

  // R6: budget is zero outside the strobe
  a_r6_quiet_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    !step_stb |-> (step_cnt == '0));

endmodule

// File: rtl/stepper_trap_profile.sv
module stepper_trap_profile
  import stp_prof_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PK_W    = 3,
  parameter int MAX_LVL = 4,
  parameter int LVL_W   = $clog2(MAX_LVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CNT_W-1:0] cmd_steps,
  input  logic [PK_W-1:0]  cmd_peak,
  input  logic             tick,
  output logic             step_stb,
  output logic [LVL_W-1:0] step_cnt,
  output logic             step_dir,
  output logic             busy,
  output logic             done
);

  phase_e           phase;
  logic             load;
  logic [CNT_W-1:0] mag;
  logic [LVL_W-1:0] peak_q;
  logic [CNT_W-1:0] remaining;
  logic [LVL_W-1:0] lvl;
  logic [LVL_W-1:0] nxt_lvl;

  assign phase     = busy ? PH_RUN : PH_IDLE;
  assign cmd_ready = (phase == PH_IDLE);
  assign load      = cmd_valid && cmd_ready;

  stp_cmd_latch #(
    .CNT_W(CNT_W), .PK_W(PK_W), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load),
    .cmd_steps(cmd_steps), .cmd_peak(cmd_peak),
    .mag(mag), .dir_q(step_dir), .peak_q(peak_q)
  );

  stp_level_sel #(
    .CNT_W(CNT_W), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .peak(peak_q),
    .remaining(remaining), .nxt_lvl(nxt_lvl)
  );

  stp_budget #(
    .CNT_W(CNT_W), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W)
  ) u_budget (
    .clk(clk), .rst_n(rst_n), .load(load), .load_mag(mag), .tick(tick),
    .nxt_lvl(nxt_lvl), .remaining(remaining), .lvl(lvl), .busy(busy),
    .step_stb(step_stb), .step_cnt(step_cnt), .done(done)
  );

  // R1: a transfer always starts a move or finishes a zero-length one
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy || done));

  // R7: completion is never reported while still running
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: direction frozen while a move runs
  a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(step_dir));

  // R2: no budget above the latched top speed
  a_r2_cap: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb |-> ((step_cnt != '0) && (step_cnt <= peak_q)));

endmodule

// File: tb/tb_stepper_trap_profile.sv
module tb_stepper_trap_profile;

  localparam int CNT_W = 16;
  localparam int PK_W  = 3;
  localparam int LVL_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [CNT_W-1:0] cmd_steps = '0;
  logic [PK_W-1:0]  cmd_peak = '0;
  logic             tick = 1'b0;
  logic             step_stb;
  logic [LVL_W-1:0] step_cnt;
  logic             step_dir;
  logic             busy;
  logic             done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  stepper_trap_profile dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_steps(cmd_steps), .cmd_peak(cmd_peak), .tick(tick),
    .step_stb(step_stb), .step_cnt(step_cnt), .step_dir(step_dir),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_peak(input int pk);
    if (pk == 0) return 1;
    if (pk > 4) return 4;
    return pk;
  endfunction

  function automatic int tri_n(input int v);
    return v * (v + 1) / 2;
  endfunction

  // R5 rule: largest of up/hold/down whose ramp-down sum fits
  function automatic int pick(input int prev, input int top, input int rem);
    int up, dn;
    up = (prev < top) ? prev + 1 : prev;
    dn = (prev > 1) ? prev - 1 : 1;
    if (up >= 1 && tri_n(up) <= rem) return up;
    if (prev >= 1 && tri_n(prev) <= rem) return prev;
    return dn;
  endfunction

  task automatic do_move(input int steps, input int pk, input int gap_max,
                         input bit tick_on_accept, input bit junk);
    int mag, top, rem, prev, sum, v, n;
    mag = (steps < 0) ? -steps : steps;
    top = eff_peak(pk);
    check("R1 ready before command", int'(cmd_ready), 1);
    cmd_valid = 1'b1;
    cmd_steps = CNT_W'(steps);
    cmd_peak  = PK_W'(pk);
    tick      = tick_on_accept;
    @(negedge clk);
    cmd_valid = 1'b0;
    tick      = 1'b0;
    if (tick_on_accept) check("R6 no strobe on accept tick", int'(step_stb), 0);
    if (mag == 0) begin
      check("R8 zero move done", int'(done), 1);
      check("R8 zero move no strobe", int'(step_stb), 0);
      check("R8 zero move not busy", int'(busy), 0);
      @(negedge clk);
      check("R7 done single pulse", int'(done), 0);
      return;
    end
    check("R1 busy after accept", int'(busy), 1);
    check("R1 ready low when busy", int'(cmd_ready), 0);
    check("R9 direction", int'(step_dir), (steps < 0) ? 1 : 0);
    rem = mag; prev = 0; sum = 0; n = 0;
    while (rem > 0) begin
      int gap;
      gap = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
      for (int g = 0; g < gap; g++) begin
        if (junk) begin
          cmd_valid = 1'b1;
          cmd_steps = CNT_W'($urandom_range(40, 1));
          cmd_peak  = PK_W'($urandom_range(7, 0));
        end
        @(negedge clk);
        if (step_stb !== 1'b0) check("R6 no strobe without tick", int'(step_stb), 0);
      end
      cmd_valid = 1'b0;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      v = pick(prev, top, rem);
      check("R6 strobe after tick", int'(step_stb), 1);
      check("R5 budget", int'(step_cnt), v);
      if (n == 0) check("R3 first budget is 1", int'(step_cnt), 1);
      else if ((int'(step_cnt) > prev + 1) || (int'(step_cnt) < prev - 1))
        check("R3 level change", int'(step_cnt), prev);
      if (int'(step_cnt) > top) check("R2 cap", int'(step_cnt), top);
      check("R9 direction held", int'(step_dir), (steps < 0) ? 1 : 0);
      sum += int'(step_cnt);
      rem -= v;
      prev = v;
      n++;
      if (rem == 0) begin
        check("R7 done with last strobe", int'(done), 1);
        check("R7 busy low at done", int'(busy), 0);
        check("R5 last budget is 1", int'(step_cnt), 1);
      end else if (done !== 1'b0) begin
        check("R7 early done", int'(done), 0);
      end
      if (n > 70000) break;
    end
    check("R4 total steps", sum, mag);
    @(negedge clk);
    check("R1 no move from ignored offers", int'(busy), 0);
    check("R6 strobe single pulse", int'(step_stb), 0);
    check("R7 done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy in reset", int'(busy), 0);
    check("R10 done in reset", int'(done), 0);
    check("R10 stb in reset", int'(step_stb), 0);
    check("R10 cnt in reset", int'(step_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready after reset", int'(cmd_ready), 1);
    check("R10 busy after reset", int'(busy), 0);

    // R6 idle tick is ignored
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R6 idle tick no strobe", int'(step_stb), 0);

    // directed corners
    do_move(0, 3, 0, 1'b0, 1'b0);      // R8
    do_move(1, 4, 0, 1'b1, 1'b0);      // R6 tick on accept
    do_move(-1, 4, 1, 1'b0, 1'b0);     // R9
    do_move(2, 4, 0, 1'b0, 1'b0);
    do_move(10, 4, 2, 1'b0, 1'b1);     // R5 triangle 1,2,3,2,1,1 and R1 junk
    do_move(50, 0, 1, 1'b0, 1'b1);     // R2 zero peak counts as 1
    do_move(-60, 7, 1, 1'b0, 1'b1);    // R2 peak clamp to 4
    do_move(30, 2, 0, 1'b0, 1'b0);
    do_move(-32768, 7, 0, 1'b0, 1'b0); // R4 most negative count
    do_move(32767, 4, 0, 1'b0, 1'b0);

    // constrained random
    for (int i = 0; i < 40; i++) begin
      int s;
      s = int'($urandom_range(240, 0)) - 120;
      do_move(s, int'($urandom_range(7, 0)), int'($urandom_range(3, 0)),
              1'b0, bit'($urandom_range(1, 0)));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule